// File: doc/BRIEF.md
# Core Timer with Overflow and Periodic Interrupts

This block is a small timebase for a CPU subsystem. An 8-bit counter advances by one on every cycle in which the count-enable input is high. Software reads the counter through a byte-wide port. Two event sources come from the counter. The first is a wrap event, raised when the counter rolls from its top value to zero. The second is a periodic event, raised every 2^(8+n) counts, where n is a 2-bit rate field.

Each event sets a sticky flag. The flag and its enable share one control and status byte. The two gated flags are ORed into a single interrupt request line, so one service routine handles both sources. Inside that routine, software reads the status byte to find which source fired. It then writes a 0 to that source's acknowledge bit to clear the flag.

Register select 0 addresses the control and status byte. Register select 1 addresses the counter, which is read-only. The read data is a combinational mux of the selected register.

Top module: `tick_timer_irq`

## Requirements
- R1: After reset the counter reads 0x00. It increases by one on each clock with `tick_en` high, holds its value when `tick_en` is low, and wraps from 0xFF to 0x00.
- R2: The wrap flag (status bit 7) becomes 1 on the clock where a counted tick takes the counter from 0xFF to 0x00. It is visible from the following cycle.
- R3: The periodic flag (status bit 6) becomes 1 on every tick that completes a multiple of 2^(8+n) counted ticks since reset. Here n is the rate field in status bits 1:0, and the rate used is the one held before that tick.
- R4: `irq` is high exactly when (wrap flag AND wrap enable at bit 5) OR (periodic flag AND periodic enable at bit 4).
- R5: Writing the status byte with bit 3 at 0 clears the wrap flag, and with bit 2 at 0 clears the periodic flag. A 1 in either acknowledge bit leaves the flag unchanged.
- R6: When an acknowledge write and a set event for the same flag fall in the same cycle, the flag is 1 afterwards.
- R7: After reset the status byte reads 0x0C: both flags 0, both enables 0, rate 0. The acknowledge bits 3 and 2 always read as 1.
- R8: Writes to register select 1 (the counter) leave the counter value unchanged.
- R9: A write to the status byte loads bits 5, 4 and 1:0 and reads them back. It never sets a flag, and bits 7:6 of the write data are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable, one count per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status/control byte, 1 = counter |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Combined interrupt request |

## Verification
Two events can land on the same clock edge: a hardware set of a flag and a software acknowledge of that same flag. The bench counts the counter up to 0xFF. On the final wrap tick it presents an acknowledge write of the wrap flag in the same cycle. The wrap flag must then read 1. The periodic flag, which is not acknowledged in that write, must also reach its expected state. A second case lands a rate change and a periodic boundary in the same cycle. The flag must follow the rate that was held before the write.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int DATA_W     = 8;
    localparam int DEF_CNT_W  = 8;
    localparam int DEF_RATE_W = 2;

    // event source indices in flag / enable vectors
    localparam int NSRC    = 2;
    localparam int SRC_RT  = 0;
    localparam int SRC_OVF = 1;

    // status byte bit positions (software-visible layout)
    localparam int B_OVF_FLAG = 7;
    localparam int B_RT_FLAG  = 6;
    localparam int B_OVF_EN   = 5;
    localparam int B_RT_EN    = 4;
    localparam int B_OVF_ACK  = 3;
    localparam int B_RT_ACK   = 2;

    typedef enum logic {
        SEL_CSR = 1'b0,
        SEL_CNT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic       ovf_en;
        logic       rt_en;
        logic [1:0] rate;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{ovf_en: 1'b0, rt_en: 1'b0, rate: 2'd0};

    function automatic logic [DATA_W-1:0] pack_status(input logic [NSRC-1:0] flags,
                                                      input ctrl_t c);
        logic [DATA_W-1:0] b;
        b             = '0;
        b[B_OVF_FLAG] = flags[SRC_OVF];
        b[B_RT_FLAG]  = flags[SRC_RT];
        b[B_OVF_EN]   = c.ovf_en;
        b[B_RT_EN]    = c.rt_en;
        b[B_OVF_ACK]  = 1'b1;
        b[B_RT_ACK]   = 1'b1;
        b[1:0]        = c.rate;
        return b;
    endfunction

endpackage

// File: rtl/tick_counter.sv
module tick_counter
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int RATE_W = DEF_RATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic [CNT_W-1:0]  cnt,
    output logic [NSRC-1:0]   hit
);
    localparam int EXT_W = CNT_W + (1 << RATE_W) - 1;

    logic [EXT_W-1:0] ext_q;
    logic [EXT_W-1:0] period_mask;

    always_ff @(posedge clk) begin
        if (rst)
            ext_q <= '0;
        else if (tick)
            ext_q <= ext_q + 1'b1;
    end

    // low CNT_W+rate bits all ones means the next tick closes a period
    always_comb begin
        for (int i = 0; i < EXT_W; i++)
            period_mask[i] = (i < CNT_W + int'(rate));
    end

    always_comb begin
        hit          = '0;
        hit[SRC_OVF] = tick && (&ext_q[CNT_W-1:0]);
        hit[SRC_RT]  = tick && ((ext_q & period_mask) == period_mask);
    end

    assign cnt = ext_q[CNT_W-1:0];

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt)); // R1
endmodule

// File: rtl/flag_cell.sv
module flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set && clr) |=> flag); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag); // R5
endmodule

// File: rtl/csr_regs.sv
module csr_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   flags,
    input  logic [CNT_W-1:0]  cnt,
    output ctrl_t             ctrl,
    output logic [NSRC-1:0]   clr,
    output logic [DATA_W-1:0] rdata
);
    reg_sel_e sel_e;
    logic     csr_wr;

    assign sel_e  = reg_sel_e'(sel);
    assign csr_wr = wr && (sel_e == SEL_CSR);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= CTRL_RESET;
        else if (csr_wr) begin
            ctrl.ovf_en <= wdata[B_OVF_EN];
            ctrl.rt_en  <= wdata[B_RT_EN];
            ctrl.rate   <= wdata[1:0];
        end
    end

    always_comb begin
        clr          = '0;
        clr[SRC_OVF] = csr_wr && !wdata[B_OVF_ACK];
        clr[SRC_RT]  = csr_wr && !wdata[B_RT_ACK];
    end

    always_comb begin
        case (sel_e)
            SEL_CSR: rdata = pack_status(flags, ctrl);
            default: rdata = DATA_W'(cnt);
        endcase
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !csr_wr |=> $stable(ctrl)); // R9
endmodule

// File: rtl/tick_timer_irq.sv
module tick_timer_irq
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int RATE_W = DEF_RATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] cnt;
    logic [NSRC-1:0]  hit;
    logic [NSRC-1:0]  clr;
    logic [NSRC-1:0]  flags;
    logic [NSRC-1:0]  en_vec;
    ctrl_t            ctrl;

    tick_counter #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_en),
        .rate (ctrl.rate),
        .cnt  (cnt),
        .hit  (hit)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_flag
        flag_cell u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (hit[s]),
            .clr  (clr[s]),
            .flag (flags[s])
        );
    end

    csr_regs #(.CNT_W(CNT_W)) u_csr (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .flags (flags),
        .cnt   (cnt),
        .ctrl  (ctrl),
        .clr   (clr),
        .rdata (reg_rdata)
    );

    always_comb begin
        en_vec          = '0;
        en_vec[SRC_OVF] = ctrl.ovf_en;
        en_vec[SRC_RT]  = ctrl.rt_en;
    end

    assign irq = |(flags & en_vec);

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (tick_en && (&cnt)) |=> flags[SRC_OVF]); // R2
    AST_RT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[SRC_RT]) |-> $past(tick_en)); // R3
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.ovf_en && !ctrl.rt_en) |-> !irq); // R4
endmodule

// File: tb/tick_timer_irq_bench.sv
`timescale 1ns/1ps
module tick_timer_irq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    always #2.5 clk = ~clk;

    tick_timer_irq u_tick_timer_irq (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct {
        string      req;
        logic [7:0] exp_d;
        logic       exp_irq;
    } item_t;

    item_t queue_q[$];
    event  probe_ev;
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // reference model state, built from the requirements
    int   m_ticks = 0;
    logic m_ovf = 0, m_rt = 0, m_oen = 0, m_ren = 0;
    logic [1:0] m_rate = 0;

    function automatic logic [7:0] m_status();
        return {m_ovf, m_rt, m_oen, m_ren, 1'b1, 1'b1, m_rate};
    endfunction

    // one clock: drive at negedge, update model at posedge
    task automatic cyc(input logic te, input logic wr, input logic sel, input logic [7:0] wd);
        logic s_ovf, s_rt;
        tick_en = te; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        @(posedge clk);
        s_ovf = 0; s_rt = 0;
        if (te) begin
            m_ticks = m_ticks + 1;
            s_ovf = (m_ticks % 256) == 0;
            s_rt  = (m_ticks % (1 << (8 + m_rate))) == 0;
        end
        if (wr && !sel) begin
            m_ovf = s_ovf ? 1'b1 : (!wd[3] ? 1'b0 : m_ovf);
            m_rt  = s_rt  ? 1'b1 : (!wd[2] ? 1'b0 : m_rt);
            m_oen = wd[5]; m_ren = wd[4]; m_rate = wd[1:0];
        end else begin
            m_ovf = m_ovf | s_ovf;
            m_rt  = m_rt  | s_rt;
        end
        @(negedge clk);
        tick_en = 0; reg_wr = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic ticks_to(input int target);
        ticks(target - m_ticks);
    endtask

    task automatic wr_csr(input logic [7:0] d);
        cyc(1'b0, 1'b1, 1'b0, d);
    endtask

    // driver: select register, push expected item, hand over to monitor
    task automatic probe(input logic sel, input string req);
        item_t it;
        reg_sel    = sel;
        it.req     = req;
        it.exp_d   = sel ? 8'(m_ticks % 256) : m_status();
        it.exp_irq = (m_ovf & m_oen) | (m_rt & m_ren);
        queue_q.push_back(it);
        -> probe_ev;
        #2;
    endtask

    // monitor: pop and compare
    initial begin
        forever begin
            item_t it;
            @(probe_ev);
            #1;
            it = queue_q.pop_front();
            n_vec++;
            if (reg_rdata !== it.exp_d || irq !== it.exp_irq) begin
                n_fail++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         it.req, reg_rdata, irq, it.exp_d, it.exp_irq);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        probe(1'b0, "R7 reset status 0x0C");
        probe(1'b1, "R1 reset counter zero");

        ticks(5);
        probe(1'b1, "R1 counts ticks");
        repeat (3) cyc(1'b0, 1'b0, 1'b0, 8'h00);
        probe(1'b1, "R1 holds without tick");

        cyc(1'b0, 1'b1, 1'b1, 8'hAA);
        probe(1'b1, "R8 counter write ignored");

        ticks_to(255);
        probe(1'b0, "R2 no wrap flag at 0xFF");
        ticks(1);
        probe(1'b1, "R1 wrap to 0x00");
        probe(1'b0, "R2 R3 flags set on wrap, R4 masked");

        wr_csr(8'hEC);  // ovf_en, acks 1, flag bits in data ignored
        probe(1'b0, "R9 enable write keeps flags");
        wr_csr(8'h24);  // ack wrap flag only
        probe(1'b0, "R5 wrap ack clears wrap flag only, R4 irq drops");
        wr_csr(8'h1C);  // rt_en
        probe(1'b0, "R4 periodic enable raises irq");
        wr_csr(8'h18);  // ack periodic
        probe(1'b0, "R5 periodic ack clears");

        wr_csr(8'h0D);  // rate 1, enables off
        probe(1'b0, "R9 rate readback");
        ticks_to(512);
        probe(1'b0, "R3 rate1 period 512");
        wr_csr(8'h01);
        ticks_to(768);
        probe(1'b0, "R3 no periodic flag at 768 with rate1");

        wr_csr(8'h35);  // both enables, ack wrap, rate 1
        ticks_to(1023);
        cyc(1'b1, 1'b1, 1'b0, 8'h35);  // wrap tick and wrap ack together
        probe(1'b0, "R6 set wins over ack");
        probe(1'b1, "R1 counter after simultaneous cycle");

        wr_csr(8'h03);  // ack both, rate 3, enables off
        probe(1'b0, "R5 both acks clear");
        ticks_to(1536);
        probe(1'b0, "R3 rate3 no flag at 1536");
        wr_csr(8'h07);  // ack wrap only, keep rate 3
        ticks_to(2047);
        cyc(1'b1, 1'b1, 1'b0, 8'h0C);  // rate change to 0 on the period boundary
        probe(1'b0, "R3 boundary uses rate held before write");

        done = 1'b1;
        #5;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule